// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus: an active-high address-latch strobe (`ale`) and an active-low program-fetch read strobe (`psen_n`). Each machine cycle is twelve oscillator periods long and is split into two six-period halves. Each strobe may fire once in each half, at a fixed offset and for a fixed width.

The instruction sequencer marks the first period of each machine cycle with `cyc_start`. In that same period it presents four qualifiers for the cycle: an external data access is in progress, a table-read instruction is executing, code is fetched from external program memory, and the address-latch suppression bit is set. The block latches the qualifiers on the marker and holds them for the whole cycle. If no marker arrives, the phase counter wraps by itself and the previous qualifiers remain in force.

An external data access drops the first-half address-latch pulse and both fetch strobes. The suppression bit mutes the address-latch strobe except in data-access or table-read cycles. External execution overrides the suppression bit. Both strobes are registered, so they change one clock after the edge that brings the phase into view.

Top module: `bus_strobe_gen`

## Requirements
- R1: After reset, and until the first `cyc_start` is sampled, `ale` is 0 and `psen_n` is 1, whatever the other inputs are.
- R2: The clock edge that samples `cyc_start` high is phase 0. In the period after the edge of phase p (0..11), the outputs show phase p. With no data access and suppression off, `ale` is 1 exactly at half-offsets 0 and 1 (phases 0, 1, 6, 7), which gives two pulses per cycle.
- R3: With external execution set and no data access, `psen_n` is 0 exactly at half-offsets 2, 3 and 4 (phases 2–4 and 8–10). Without external execution, `psen_n` stays 1.
- R4: In a cycle flagged as an external data access, the first-half `ale` pulse (phases 0, 1) is dropped and the second-half pulse (phases 6, 7) is kept.
- R5: In a cycle flagged as an external data access, `psen_n` stays 1 for all twelve phases.
- R6: With suppression set, external execution clear, and neither a data access nor a table read, `ale` stays 0 for the whole cycle.
- R7: With suppression set, a table-read cycle gives both `ale` pulses, and a data-access cycle gives only the second-half pulse.
- R8: When external execution is set, the suppression bit has no effect on `ale`.
- R9: The qualifiers are sampled only when `cyc_start` is high. Changes to them during the rest of the cycle, or during a cycle entered by wrap-around, do not alter the outputs.
- R10: A `cyc_start` in the middle of a cycle restarts the phase at 0. Without a marker, phase 11 is followed by phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | Marks phase 0 of a machine cycle |
| xdata_acc | input | 1 | Cycle performs an external data access |
| tbl_read | input | 1 | Table-read instruction in this cycle |
| ext_exec | input | 1 | Code is fetched from external program memory |
| ale_off | input | 1 | Address-latch suppression bit |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-fetch read strobe, active low |

## Verification
A corrupted phase counter moves a pulse to the wrong phase. A wrongly latched qualifier adds or removes a whole pulse. Either fault shows at the pins within the next six-period half, at the latest by the next strobe window.

The bench drives every combination of the four qualifiers through a full cycle and compares both strobes at each of the twelve phases. It then repeats cycles with the qualifiers changed mid-cycle, with a marker in the middle of a cycle, and with wrap-around and no marker. In all of these, a stale or mis-sampled state differs from the expected pattern within one cycle.

// File: rtl/bus_strobe_pkg.sv
`timescale 1ns/1ps
package bus_strobe_pkg;

    typedef struct packed {
        logic xdata;
        logic tblrd;
        logic xexec;
        logic aledis;
    } cyc_flags_t;

    localparam cyc_flags_t FLAGS_IDLE = '{xdata: 1'b0, tblrd: 1'b0, xexec: 1'b0, aledis: 1'b0};

endpackage

// File: rtl/bus_strobe_phase.sv
`timescale 1ns/1ps
module bus_strobe_phase #(
    parameter int CYC_LEN = 12,
    localparam int PW = $clog2(CYC_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    output logic [PW-1:0] phase_nxt,
    output logic [PW-1:0] phase_q
);
    localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

    logic [PW-1:0] phase_d;

    always_comb begin
        if (cyc_start)
            phase_d = '0;
        else if (phase_q == LAST)
            phase_d = '0;
        else
            phase_d = phase_q + 1'b1;
    end

    assign phase_nxt = phase_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= LAST;
        else
            phase_q <= phase_d;
    end

    // R10
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> (phase_q == '0));

    // R10
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && phase_q != LAST) |=> (phase_q == $past(phase_q) + 1'b1));

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && phase_q == LAST) |=> (phase_q == '0));

endmodule

// File: rtl/bus_strobe_decode.sv
`timescale 1ns/1ps
module bus_strobe_decode
    import bus_strobe_pkg::*;
#(
    parameter int CYC_LEN  = 12,
    parameter int ALE_W    = 2,
    parameter int PSEN_OFS = 2,
    parameter int PSEN_W   = 3,
    localparam int PW      = $clog2(CYC_LEN),
    localparam int HALF    = CYC_LEN / 2,
    localparam int OW      = $clog2(HALF)
) (
    input  logic          run,
    input  logic [PW-1:0] phase,
    input  cyc_flags_t    flg,
    output logic          ale_nxt,
    output logic          psen_nxt_n
);
    logic [HALF-1:0] ale_mask;
    logic [HALF-1:0] psen_mask;

    generate
        for (genvar i = 0; i < HALF; i++) begin : g_slot
            assign ale_mask[i]  = (i < ALE_W);
            assign psen_mask[i] = (i >= PSEN_OFS) && (i < PSEN_OFS + PSEN_W);
        end
    endgenerate

    logic          second_half;
    logic [OW-1:0] off;
    logic          ale_allowed;
    logic          ale_dropped;
    logic          fetch_on;

    always_comb begin
        second_half = (phase >= PW'(HALF));
        off         = second_half ? OW'(phase - PW'(HALF)) : OW'(phase);
        // suppression is honoured only while executing internally
        ale_allowed = !(flg.aledis && !flg.xexec) || flg.xdata || flg.tblrd;
        ale_dropped = flg.xdata && !second_half;
        fetch_on    = flg.xexec && !flg.xdata;
        ale_nxt     = run && ale_mask[off] && ale_allowed && !ale_dropped;
        psen_nxt_n  = !(run && fetch_on && psen_mask[off]);
    end

endmodule

// File: rtl/bus_strobe_gen.sv
`timescale 1ns/1ps
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int CYC_LEN  = 12,
    parameter int ALE_W    = 2,
    parameter int PSEN_OFS = 2,
    parameter int PSEN_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic xdata_acc,
    input  logic tbl_read,
    input  logic ext_exec,
    input  logic ale_off,
    output logic ale,
    output logic psen_n
);
    localparam int PW   = $clog2(CYC_LEN);
    localparam int HALF = CYC_LEN / 2;

    typedef struct packed {
        logic       run;
        cyc_flags_t flg;
        logic       ale;
        logic       psen_n;
    } strobe_st_t;

    strobe_st_t st_d, st_q;

    logic [PW-1:0] phase_nxt, phase_q;
    cyc_flags_t    flg_in, flg_nxt;
    logic          run_nxt;
    logic          ale_nxt, psen_nxt_n;

    assign flg_in  = '{xdata: xdata_acc, tblrd: tbl_read, xexec: ext_exec, aledis: ale_off};
    assign flg_nxt = cyc_start ? flg_in : st_q.flg;
    assign run_nxt = st_q.run || cyc_start;

    bus_strobe_phase #(.CYC_LEN(CYC_LEN)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .phase_nxt (phase_nxt),
        .phase_q   (phase_q)
    );

    bus_strobe_decode #(
        .CYC_LEN  (CYC_LEN),
        .ALE_W    (ALE_W),
        .PSEN_OFS (PSEN_OFS),
        .PSEN_W   (PSEN_W)
    ) u_decode (
        .run        (run_nxt),
        .phase      (phase_nxt),
        .flg        (flg_nxt),
        .ale_nxt    (ale_nxt),
        .psen_nxt_n (psen_nxt_n)
    );

    always_comb begin
        st_d        = st_q;
        st_d.run    = run_nxt;
        st_d.flg    = flg_nxt;
        st_d.ale    = ale_nxt;
        st_d.psen_n = psen_nxt_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run    <= 1'b0;
            st_q.flg    <= FLAGS_IDLE;
            st_q.ale    <= 1'b0;
            st_q.psen_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ale    = st_q.ale;
    assign psen_n = st_q.psen_n;

    // R1
    idle_before_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (!ale && psen_n));

    // R3
    strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !psen_n));

    // R4
    xdata_first_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flg.xdata && phase_q < PW'(HALF)) |-> !ale);

    // R5
    xdata_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flg.xdata |-> psen_n);

    // R6
    ale_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flg.aledis && !st_q.flg.xexec && !st_q.flg.xdata && !st_q.flg.tblrd) |-> !ale);

    // R9
    flags_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(st_q.flg));

endmodule

// File: tb/bus_strobe_gen_bench.sv
`timescale 1ns/1ps
module bus_strobe_gen_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0;
    logic xdata_acc = 1'b0, tbl_read = 1'b0, ext_exec = 1'b0, ale_off = 1'b0;
    logic ale, psen_n;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bus_strobe_gen u_bus_strobe_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .xdata_acc (xdata_acc),
        .tbl_read  (tbl_read),
        .ext_exec  (ext_exec),
        .ale_off   (ale_off),
        .ale       (ale),
        .psen_n    (psen_n)
    );

    // flag word: [3] data access, [2] table read, [1] external execution, [0] suppression
    task automatic apply(input logic [3:0] f);
        xdata_acc = f[3];
        tbl_read  = f[2];
        ext_exec  = f[1];
        ale_off   = f[0];
    endtask

    task automatic check(input int p, input logic [3:0] f, input string tag);
        int  off   = p % 6;
        bit  first = (p < 6);
        bit  e_ale;
        bit  e_psn;
        e_ale = (off < 2) && (!(f[0] && !f[1]) || f[3] || f[2]) && !(f[3] && first);
        e_psn = !(f[1] && !f[3] && off >= 2 && off <= 4);
        n_vec++;
        if (ale !== e_ale || psen_n !== e_psn) begin
            n_bad++;
            $display("FAIL %s flags=%b phase=%0d ale=%b/%b psen_n=%b/%b (actual/expected)",
                     tag, f, p, ale, e_ale, psen_n, e_psn);
        end
    endtask

    // strobe: assert cyc_start; disturb: scramble inputs from phase 5 on
    task automatic run_cyc(input logic [3:0] f, input bit strobe, input int nph,
                           input bit disturb, input string tag);
        if (strobe) begin
            cyc_start = 1'b1;
            apply(f);
        end else begin
            apply(~f);
        end
        for (int p = 0; p < nph; p++) begin
            @(negedge clk);
            check(p, f, tag);
            if (p == 0) cyc_start = 1'b0;
            if (disturb && p == 5) apply(~f);
        end
    endtask

    function automatic string tag_of(input logic [3:0] f);
        if (f[3])                  return "R4,R5,R7";
        if (f[0] && f[1])          return "R8";
        if (f[0] && f[2])          return "R7";
        if (f[0])                  return "R6";
        if (f[1])                  return "R3";
        return "R2";
    endfunction

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        apply(4'b0010);
        repeat (3) @(negedge clk);
        // R1: outputs idle during and after reset until a marker arrives
        n_vec++;
        if (ale !== 1'b0 || psen_n !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 in reset ale=%b/0 psen_n=%b/1", ale, psen_n);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n_vec++;
            if (ale !== 1'b0 || psen_n !== 1'b1) begin
                n_bad++;
                $display("FAIL R1 pre-sync ale=%b/0 psen_n=%b/1", ale, psen_n);
            end
        end

        // exhaustive sweep of every qualifier combination, all twelve phases
        for (int k = 0; k < 16; k++)
            run_cyc(4'(k), 1'b1, 12, 1'b0, tag_of(4'(k)));

        // R9: qualifiers changed after phase 5 must not matter
        for (int k = 0; k < 16; k++)
            run_cyc(4'(k), 1'b1, 12, 1'b1, "R9");

        // R10: wrap-around without a marker keeps the latched qualifiers (R9 too)
        for (int k = 0; k < 16; k += 3) begin
            run_cyc(4'(k), 1'b1, 12, 1'b0, "R10");
            run_cyc(4'(k), 1'b0, 12, 1'b0, "R10");
        end

        // R10: marker in mid-cycle restarts at phase 0
        for (int k = 1; k < 12; k++) begin
            run_cyc(4'b0010, 1'b1, k, 1'b0, "R10");
            run_cyc(4'b1001, 1'b1, 12, 1'b0, "R10");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule